// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block is the reservation unit that sits beside one processor's cache and makes a load-linked / store-conditional pair behave as an atomic read-modify-write. A load-linked request records the block address of the access and arms a single reservation flag. Between that load and the matching store-conditional, the unit watches two kinds of event: invalidations snooped from the bus and evictions from the local cache. Either one clears the reservation when it targets the recorded block.

When the processor issues a store-conditional, the unit decides in the same cycle whether the store may write. It raises `wr_grant` only if the reservation is still armed. One cycle later it reports the outcome on `rsp_valid` and `rsp_ok`. Every store-conditional consumes the reservation, whether it succeeds or not. Addresses are compared at block granularity: the low `OFF_W` bits are the offset within a block and take no part in any comparison.

Top module: `resv_monitor`

## Requirements
- R1: After reset the reservation is clear and `rsp_valid`, `rsp_ok` and `wr_grant` are low, so a store-conditional issued first after reset fails.
- R2: A load-linked (`ll_req` high for one cycle) arms the reservation and records the block of `cpu_addr`; a later store-conditional with no intervening kill sees `wr_grant` high.
- R3: `wr_grant` is high in the cycle `sc_req` is high exactly when the reservation is armed and not killed that same cycle; the address presented with the store-conditional takes no part in the decision.
- R4: One cycle after each cycle with `sc_req` high, `rsp_valid` is high for one cycle and `rsp_ok` equals the `wr_grant` of that store-conditional; otherwise both are low.
- R5: A snooped invalidation (`snp_inv` high) whose address has the same block bits [ADDR_W-1:OFF_W] as the recorded address clears the reservation, whatever its offset bits; one to a different block has no effect.
- R6: Every store-conditional clears the reservation, so a second store-conditional without a new load-linked fails.
- R7: A local eviction (`evict` high) of the recorded block clears the reservation; an eviction of another block has no effect.
- R8: A matching invalidation or eviction in the same cycle as a store-conditional wins: `wr_grant` stays low and the store-conditional fails.
- R9: A load-linked in the same cycle as an invalidation or eviction of its own block leaves the reservation clear.
- R10: A new load-linked replaces the recorded block, so an invalidation of the previously recorded block no longer clears the reservation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ll_req | input | 1 | Load-linked request, one cycle per request |
| sc_req | input | 1 | Store-conditional request, one cycle per request |
| cpu_addr | input | ADDR_W | Processor request address |
| snp_inv | input | 1 | Snooped invalidation or read-exclusive pulse |
| snp_addr | input | ADDR_W | Address of the snooped invalidation |
| evict | input | 1 | Local cache eviction pulse |
| evict_addr | input | ADDR_W | Address of the evicted block |
| wr_grant | output | 1 | Same-cycle permission for the store-conditional to write |
| rsp_valid | output | 1 | Store-conditional result valid, one cycle after the request |
| rsp_ok | output | 1 | Store-conditional succeeded |

## Verification
The assertions assume that the processor never raises `ll_req` and `sc_req` in the same cycle. One checker property flags any cycle where it does, and the properties on the reservation flag hold only under that rule. Each directed task in the bench drives at most one of the two requests per cycle. The snoop and eviction pulses are left free to coincide with either request, so that the same-cycle cases R8 and R9 are exercised.

// File: rtl/resv_pkg.sv
package resv_pkg;
  localparam int MAX_AW = 64;

  // True when two addresses fall in the same block, offset bits ignored.
  function automatic logic same_blk(input logic [MAX_AW-1:0] a,
                                    input logic [MAX_AW-1:0] b,
                                    input int unsigned off_w);
    return ((a ^ b) >> off_w) == '0;
  endfunction
endpackage

// File: rtl/blk_cmp.sv
module blk_cmp #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 6
) (
  input  logic              en,
  input  logic [ADDR_W-1:0] a,
  input  logic [ADDR_W-1:0] b,
  output logic              hit
);
  import resv_pkg::*;
  assign hit = en & same_blk(MAX_AW'(a), MAX_AW'(b), OFF_W);
endmodule

// File: rtl/resv_state.sv
module resv_state #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ll,
  input  logic              sc,
  input  logic              kill,
  input  logic [ADDR_W-1:0] ll_addr,
  output logic              flag_q,
  output logic [ADDR_W-1:0] lock_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      lock_q <= '0;
    end else begin
      if (ll) lock_q <= ll_addr;
      if (kill || sc)  flag_q <= 1'b0;
      else if (ll)     flag_q <= 1'b1;
    end
  end
endmodule

// File: rtl/sc_resp.sv
module sc_resp (
  input  logic clk,
  input  logic rst_n,
  input  logic sc,
  input  logic grant,
  output logic rsp_valid,
  output logic rsp_ok
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_ok    <= 1'b0;
    end else begin
      rsp_valid <= sc;
      rsp_ok    <= sc & grant;
    end
  end
endmodule

// File: rtl/resv_monitor.sv
module resv_monitor #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ll_req,
  input  logic              sc_req,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              snp_inv,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic              evict,
  input  logic [ADDR_W-1:0] evict_addr,
  output logic              wr_grant,
  output logic              rsp_valid,
  output logic              rsp_ok
);
  localparam int N_SRC = 2;  // kill sources: 0 snoop, 1 eviction

  logic              flag_q;
  logic [ADDR_W-1:0] lock_q;
  logic [ADDR_W-1:0] cmp_base;
  logic [N_SRC-1:0]  src_en;
  logic [ADDR_W-1:0] src_addr [N_SRC];
  logic [N_SRC-1:0]  src_hit;
  logic              snp_hit, evc_hit, kill_ev;

  // With a load-linked in flight, kills aim at the block being reserved.
  assign cmp_base    = ll_req ? cpu_addr : lock_q;
  assign src_en[0]   = snp_inv;
  assign src_addr[0] = snp_addr;
  assign src_en[1]   = evict;
  assign src_addr[1] = evict_addr;

  for (genvar i = 0; i < N_SRC; i++) begin : g_cmp
    blk_cmp #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_cmp (
      .en (src_en[i]),
      .a  (src_addr[i]),
      .b  (cmp_base),
      .hit(src_hit[i])
    );
  end

  assign snp_hit  = src_hit[0];
  assign evc_hit  = src_hit[1];
  assign kill_ev  = |src_hit;
  assign wr_grant = sc_req & flag_q & ~kill_ev;

  resv_state #(.ADDR_W(ADDR_W)) u_state (
    .clk    (clk),
    .rst_n  (rst_n),
    .ll     (ll_req),
    .sc     (sc_req),
    .kill   (kill_ev),
    .ll_addr(cpu_addr),
    .flag_q (flag_q),
    .lock_q (lock_q)
  );

  sc_resp u_resp (
    .clk      (clk),
    .rst_n    (rst_n),
    .sc       (sc_req),
    .grant    (wr_grant),
    .rsp_valid(rsp_valid),
    .rsp_ok   (rsp_ok)
  );
endmodule

// File: rtl/resv_monitor_chk.sv
module resv_monitor_chk #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ll_req,
  input logic              sc_req,
  input logic              snp_inv,
  input logic [ADDR_W-1:0] snp_addr,
  input logic              evict,
  input logic              flag_q,
  input logic [ADDR_W-1:0] lock_q,
  input logic              snp_hit,
  input logic              kill_ev,
  input logic              wr_grant,
  input logic              rsp_valid,
  input logic              rsp_ok
);
  // Input rule: the processor never issues both requests in one cycle.
  a_in_ll_sc_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(ll_req && sc_req));

  // R3: a grant needs an armed reservation and a store-conditional.
  a_r3_grant_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    wr_grant |-> (flag_q && sc_req));

  // R4: result reported the cycle after the request.
  a_r4_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    sc_req |=> rsp_valid);
  a_r4_ok_from_grant: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ok |-> (rsp_valid && $past(wr_grant)));

  // R6: every store-conditional consumes the reservation.
  a_r6_sc_clears: assert property (@(posedge clk) disable iff (!rst_n)
    sc_req |=> !flag_q);

  // R5: a snooped invalidation of the held block clears the flag.
  a_r5_snoop_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_inv && !ll_req && ((snp_addr ^ lock_q) >> OFF_W) == '0) |=> !flag_q);

  // R8: a same-cycle kill denies the store-conditional.
  a_r8_kill_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_req && kill_ev) |-> !wr_grant);

  // R2: a clean load-linked arms the reservation.
  a_r2_ll_arms: assert property (@(posedge clk) disable iff (!rst_n)
    (ll_req && !snp_inv && !evict) |=> flag_q);

  // R9: a load-linked killed in its own cycle stays clear.
  a_r9_ll_killed: assert property (@(posedge clk) disable iff (!rst_n)
    (ll_req && snp_hit) |=> !flag_q);
endmodule

bind resv_monitor resv_monitor_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ll_req   (ll_req),
  .sc_req   (sc_req),
  .snp_inv  (snp_inv),
  .snp_addr (snp_addr),
  .evict    (evict),
  .flag_q   (flag_q),
  .lock_q   (lock_q),
  .snp_hit  (snp_hit),
  .kill_ev  (kill_ev),
  .wr_grant (wr_grant),
  .rsp_valid(rsp_valid),
  .rsp_ok   (rsp_ok)
);

// File: tb/sim_resv_monitor.sv
module sim_resv_monitor;
  localparam int AW = 32;
  localparam int OW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ll_req = 1'b0, sc_req = 1'b0, snp_inv = 1'b0, evict = 1'b0;
  logic [AW-1:0] cpu_addr = '0, snp_addr = '0, evict_addr = '0;
  logic          wr_grant, rsp_valid, rsp_ok;
  int            n_run = 0, n_fail = 0;
  bit            finished = 1'b0;

  always #4 clk = ~clk;

  resv_monitor #(.ADDR_W(AW), .OFF_W(OW)) u0 (
    .clk(clk), .rst_n(rst_n), .ll_req(ll_req), .sc_req(sc_req),
    .cpu_addr(cpu_addr), .snp_inv(snp_inv), .snp_addr(snp_addr),
    .evict(evict), .evict_addr(evict_addr), .wr_grant(wr_grant),
    .rsp_valid(rsp_valid), .rsp_ok(rsp_ok)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    ll_req = 0; sc_req = 0; snp_inv = 0; evict = 0;
  endtask

  // Load-linked at a, optionally with a same-cycle snoop/eviction.
  task automatic do_ll(input logic [AW-1:0] a, input logic sn, input logic [AW-1:0] sa,
                       input logic ev, input logic [AW-1:0] ea);
    @(negedge clk);
    ll_req = 1; cpu_addr = a; snp_inv = sn; snp_addr = sa; evict = ev; evict_addr = ea;
    idle();
  endtask

  task automatic do_snoop(input logic [AW-1:0] sa);
    @(negedge clk); snp_inv = 1; snp_addr = sa;
    idle();
  endtask

  task automatic do_evict(input logic [AW-1:0] ea);
    @(negedge clk); evict = 1; evict_addr = ea;
    idle();
  endtask

  // Store-conditional: grant checked in the request cycle, result one cycle later.
  task automatic do_sc(input string req, input logic exp, input logic [AW-1:0] a,
                       input logic sn, input logic [AW-1:0] sa);
    @(negedge clk);
    sc_req = 1; cpu_addr = a; snp_inv = sn; snp_addr = sa;
    #1 check({req, " grant"}, wr_grant, exp);
    idle();
    check({req, " rsp_valid"}, rsp_valid, 1'b1);
    check({req, " rsp_ok"}, rsp_ok, exp);
    #1;
  endtask

  task automatic t_reset();
    check("R1 rsp_valid at reset", rsp_valid, 1'b0);
    check("R1 rsp_ok at reset", rsp_ok, 1'b0);
    check("R1 wr_grant at reset", wr_grant, 1'b0);
    do_sc("R1 SC after reset", 1'b0, 32'h100, 0, 0);
    idle();
    check("R4 rsp_valid drops", rsp_valid, 1'b0);
  endtask

  task automatic t_basic();
    do_ll(32'h1000, 0, 0, 0, 0);
    do_sc("R2 LL then SC", 1'b1, 32'h1000, 0, 0);
    do_sc("R6 second SC", 1'b0, 32'h1000, 0, 0);
  endtask

  task automatic t_sc_addr_ignored();
    do_ll(32'h2040, 0, 0, 0, 0);
    do_sc("R3 SC other address", 1'b1, 32'hDEAD0000, 0, 0);
  endtask

  task automatic t_snoop();
    do_ll(32'h3000, 0, 0, 0, 0);
    do_snoop(32'h3080);
    do_sc("R5 snoop other block", 1'b1, 32'h3000, 0, 0);
    do_ll(32'h3000, 0, 0, 0, 0);
    do_snoop(32'h303C);
    do_sc("R5 snoop same block other offset", 1'b0, 32'h3000, 0, 0);
  endtask

  task automatic t_evict();
    do_ll(32'h4000, 0, 0, 0, 0);
    do_evict(32'h5000);
    do_sc("R7 evict other block", 1'b1, 32'h4000, 0, 0);
    do_ll(32'h4000, 0, 0, 0, 0);
    do_evict(32'h4010);
    do_sc("R7 evict reserved block", 1'b0, 32'h4000, 0, 0);
  endtask

  task automatic t_race();
    do_ll(32'h6000, 0, 0, 0, 0);
    do_sc("R8 SC with same-cycle snoop", 1'b0, 32'h6000, 1, 32'h6008);
    do_ll(32'h6000, 0, 0, 0, 0);
    do_sc("R8 SC with unrelated snoop", 1'b1, 32'h6000, 1, 32'h7000);
  endtask

  task automatic t_ll_killed();
    do_ll(32'h8000, 1, 32'h8004, 0, 0);
    do_sc("R9 LL with same-cycle snoop", 1'b0, 32'h8000, 0, 0);
    do_ll(32'h8000, 0, 0, 1, 32'h8020);
    do_sc("R9 LL with same-cycle eviction", 1'b0, 32'h8000, 0, 0);
  endtask

  task automatic t_replace();
    do_ll(32'h9000, 0, 0, 0, 0);
    do_ll(32'hA000, 0, 0, 0, 0);
    do_snoop(32'h9000);
    do_sc("R10 snoop of old block", 1'b1, 32'hA000, 0, 0);
    do_ll(32'h9000, 0, 0, 0, 0);
    do_ll(32'hA000, 0, 0, 0, 0);
    do_snoop(32'hA000);
    do_sc("R10 snoop of new block", 1'b0, 32'hA000, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    t_reset();
    t_basic();
    t_sc_addr_ignored();
    t_snoop();
    t_evict();
    t_race();
    t_ll_killed();
    t_replace();
    finished = 1'b1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule